// File: doc/BRIEF.md
# Two-Line CAN Interrupt Router

This block collects the interrupt sources of a CAN controller and distributes them over two interrupt outputs. Two kinds of source feed it: one completion pulse per mailbox, and three controller status pulses (warning level reached, error passive entered, bus-off entered). Each output line owns a flag register. That register holds the sticky status flags, a summary bit for mailbox activity and the number of the mailbox that currently needs service on that line.

Software configures the block through a small register port. A mailbox mask selects which mailboxes may raise interrupts. A per-mailbox line-select register sends each mailbox to line 0 or line 1. A global mask enables each line, selects the line that carries the status events, and enables each status event. Mailbox pending state is cleared by the mailbox logic through a per-mailbox clear input. Status flags are cleared by writing ones to the flag register of the line.

Top module: `can_irq_router`

## Requirements
- R1: After reset, all five registers read zero and both interrupt outputs are low.
- R2: A pulse on mailbox event input i marks mailbox i pending only when bit i of the mailbox mask (address 0) is set. A pending mailbox sets bit 15 of the flag register of the line chosen by bit i of the line-select register (address 1): 1 selects line 1 at address 4, 0 selects line 0 at address 3. A pulse on a masked-off mailbox changes nothing.
- R3: Bits 4:0 of a flag register hold the highest-numbered pending mailbox routed to that line, and are zero when none is pending. A pulse on mailbox clear input i removes mailbox i, and the field then moves to the next lower pending mailbox.
- R4: The warning, error-passive and bus-off pulses set flag bits 8, 9 and 10, and these bits stay set. They go to line 1's flag register when global mask (address 2) bit 2 is set, and to line 0's otherwise.
- R5: A register write to a flag register clears each of bits 10:8 whose written bit is one, so writing all ones clears every status flag. The write has no effect on bit 15 or bits 4:0.
- R6: Interrupt output n is a register. One cycle after the flags change, it equals global mask bit n ANDed with (flag bit 15, or any of flag bits 10:8 whose enable at the same position in global mask bits 10:8 is set).
- R7: Read data appears one cycle after the address is presented. The global mask stores only bits 0, 1, 2 and 10:8, and its other bits read zero. Unused addresses read zero.
- R8: A source event in the same cycle as its clear (a mailbox clear pulse, or a flag write of one) wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbox_evt | input | NUM_MBOX | Per-mailbox completion pulses |
| mbox_clr | input | NUM_MBOX | Per-mailbox pending clear pulses from the mailbox logic |
| warn_evt | input | 1 | Warning-level status pulse |
| passive_evt | input | 1 | Error-passive status pulse |
| busoff_evt | input | 1 | Bus-off status pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 mask, 1 line select, 2 global mask, 3 line 0 flags, 4 line 1 flags) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_line0 | output | 1 | Interrupt line 0 |
| irq_line1 | output | 1 | Interrupt line 1 |

## Verification
The hardest situations to reach are the collisions: a source event in the same cycle as its own clear, and several mailboxes pending on one line at once. In the collision case the flag must survive. With several mailboxes pending, the number field must step down through them in order as the mailbox logic retires each one. The stimulus fires mailbox events together in one cycle and then retires them one at a time. It also drives a clear pulse and an event on the same mailbox in one cycle, and a flag write together with a status pulse. Routing is reversed in the middle of the run, so that status events and mailboxes land on line 1 while line 0 is disabled.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int FLAG_WARN_BIT = 8;
  localparam int FLAG_PASS_BIT = 9;
  localparam int FLAG_BOFF_BIT = 10;
  localparam int FLAG_MBOX_BIT = 15;
  localparam int GM_SYS_L1_BIT = 2;
  localparam int NUM_LINES     = 2;
  localparam int NUM_SYS       = 3;

  typedef enum logic [2:0] {
    ADDR_MASK  = 3'd0,
    ADDR_LEVEL = 3'd1,
    ADDR_GMASK = 3'd2,
    ADDR_FLAG0 = 3'd3,
    ADDR_FLAG1 = 3'd4
  } irq_addr_e;
endpackage

// File: rtl/can_irq_cfg.sv
module can_irq_cfg
  import can_irq_pkg::*;
#(
  parameter int NUM_MBOX = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [31:0]          wdata,
  input  logic [31:0]          flag0,
  input  logic [31:0]          flag1,
  output logic [NUM_MBOX-1:0]  mbox_mask,
  output logic [NUM_MBOX-1:0]  mbox_level,
  output logic [1:0]           line_en,
  output logic                 sys_to_l1,
  output logic [NUM_SYS-1:0]   sys_en,
  output logic [1:0]           flag_wr,
  output logic [31:0]          rdata
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:11], wdata[7:3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mbox_mask  <= '0;
      mbox_level <= '0;
      line_en    <= '0;
      sys_to_l1  <= 1'b0;
      sys_en     <= '0;
    end else if (we) begin
      case (addr)
        ADDR_MASK:  mbox_mask  <= wdata[NUM_MBOX-1:0];
        ADDR_LEVEL: mbox_level <= wdata[NUM_MBOX-1:0];
        ADDR_GMASK: begin
          line_en   <= wdata[1:0];
          sys_to_l1 <= wdata[GM_SYS_L1_BIT];
          sys_en    <= wdata[FLAG_BOFF_BIT:FLAG_WARN_BIT];
        end
        default: ;
      endcase
    end
  end

  assign flag_wr[0] = we && (addr == ADDR_FLAG0);
  assign flag_wr[1] = we && (addr == ADDR_FLAG1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_MASK:  rdata <= 32'(mbox_mask);
        ADDR_LEVEL: rdata <= 32'(mbox_level);
        ADDR_GMASK: rdata <= {21'b0, sys_en, 5'b0, sys_to_l1, line_en};
        ADDR_FLAG0: rdata <= flag0;
        ADDR_FLAG1: rdata <= flag1;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/can_irq_mbox_pend.sv
module can_irq_mbox_pend #(
  parameter int NUM_MBOX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] evt,
  input  logic [NUM_MBOX-1:0] clr,
  input  logic [NUM_MBOX-1:0] mask,
  output logic [NUM_MBOX-1:0] pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | (evt & mask);
  end

  // A mailbox only becomes pending through an enabled event (R2)
  assert_pend_src_R2: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(evt & mask)) == '0);

  // Event beats a simultaneous clear (R8)
  assert_evt_wins_R8: assert property (@(posedge clk) disable iff (rst)
    |(evt & mask) |=> ((pend & $past(evt & mask)) == $past(evt & mask)));
endmodule

// File: rtl/can_irq_line.sv
module can_irq_line
  import can_irq_pkg::*;
#(
  parameter int NUM_MBOX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] pend_sel,
  input  logic [NUM_SYS-1:0]  sys_evt,
  input  logic                flag_wr,
  input  logic [NUM_SYS-1:0]  wsys,
  input  logic                line_en,
  input  logic [NUM_SYS-1:0]  sys_en,
  output logic [31:0]         flag_word,
  output logic                irq
);
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1;

  logic [NUM_SYS-1:0] sys_q;
  logic [MB_W-1:0]    top_num;
  logic               mb_any;
  logic               want;

  always_ff @(posedge clk) begin
    if (rst)          sys_q <= '0;
    else if (flag_wr) sys_q <= (sys_q & ~wsys) | sys_evt;
    else              sys_q <= sys_q | sys_evt;
  end

  always_comb begin
    top_num = '0;
    for (int i = 0; i < NUM_MBOX; i++)
      if (pend_sel[i]) top_num = MB_W'(i);
  end

  assign mb_any = |pend_sel;

  always_comb begin
    flag_word = '0;
    flag_word[MB_W-1:0] = top_num;
    flag_word[FLAG_BOFF_BIT:FLAG_WARN_BIT] = sys_q;
    flag_word[FLAG_MBOX_BIT] = mb_any;
  end

  assign want = line_en && (mb_any || |(sys_q & sys_en));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= want;
  end

  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(line_en));

  assert_sys_src_R4: assert property (@(posedge clk) disable iff (rst)
    (sys_q & ~$past(sys_q) & ~$past(sys_evt)) == '0);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && (&wsys) && !(|sys_evt)) |=> (sys_q == '0));

  assert_num_valid_R3: assert property (@(posedge clk) disable iff (rst)
    mb_any |-> pend_sel[top_num]);
endmodule

// File: rtl/can_irq_router.sv
module can_irq_router
  import can_irq_pkg::*;
#(
  parameter int NUM_MBOX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MBOX-1:0] mbox_evt,
  input  logic [NUM_MBOX-1:0] mbox_clr,
  input  logic                warn_evt,
  input  logic                passive_evt,
  input  logic                busoff_evt,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq_line0,
  output logic                irq_line1
);
  logic [NUM_MBOX-1:0] mbox_mask, mbox_level, pend;
  logic [1:0]          line_en, flag_wr, irq_v;
  logic                sys_to_l1;
  logic [NUM_SYS-1:0]  sys_en, sys_in;
  logic [31:0]         flag_v [NUM_LINES];

  assign sys_in = {busoff_evt, passive_evt, warn_evt};

  can_irq_cfg #(.NUM_MBOX(NUM_MBOX)) u_cfg (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flag0(flag_v[0]), .flag1(flag_v[1]),
    .mbox_mask(mbox_mask), .mbox_level(mbox_level), .line_en(line_en),
    .sys_to_l1(sys_to_l1), .sys_en(sys_en), .flag_wr(flag_wr),
    .rdata(reg_rdata)
  );

  can_irq_mbox_pend #(.NUM_MBOX(NUM_MBOX)) u_pend (
    .clk(clk), .rst(rst), .evt(mbox_evt), .clr(mbox_clr),
    .mask(mbox_mask), .pend(pend)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [NUM_MBOX-1:0] sel;
    logic [NUM_SYS-1:0]  sys_route;
    assign sel       = (g == 1) ? (pend & mbox_level) : (pend & ~mbox_level);
    assign sys_route = (sys_to_l1 == (g == 1)) ? sys_in : '0;

    can_irq_line #(.NUM_MBOX(NUM_MBOX)) u_line (
      .clk(clk), .rst(rst), .pend_sel(sel), .sys_evt(sys_route),
      .flag_wr(flag_wr[g]), .wsys(reg_wdata[FLAG_BOFF_BIT:FLAG_WARN_BIT]),
      .line_en(line_en[g]), .sys_en(sys_en),
      .flag_word(flag_v[g]), .irq(irq_v[g])
    );
  end

  assign irq_line0 = irq_v[0];
  assign irq_line1 = irq_v[1];

  // Status flags never appear on the line that is not selected (R4)
  assert_sys_route_R4: assert property (@(posedge clk) disable iff (rst)
    (|sys_in && !sys_to_l1 && !flag_wr[1]) |=>
      ($past(flag_v[1][FLAG_BOFF_BIT:FLAG_WARN_BIT]) == flag_v[1][FLAG_BOFF_BIT:FLAG_WARN_BIT]));
endmodule

// File: tb/can_irq_router_test.sv
module can_irq_router_test;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] mbox_evt = '0, mbox_clr = '0;
  logic warn_evt = 1'b0, passive_evt = 1'b0, busoff_evt = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_line0, irq_line1;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_req = 1'b0, rd_req_d = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_irq_router #(.NUM_MBOX(N)) uut (
    .clk(clk), .rst(rst), .mbox_evt(mbox_evt), .mbox_clr(mbox_clr),
    .warn_evt(warn_evt), .passive_evt(passive_evt), .busoff_evt(busoff_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_line0(irq_line0), .irq_line1(irq_line1)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_d && exp_q.size() > 0) chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] ev, input logic [N-1:0] cl, input logic [2:0] sys);
    @(negedge clk);
    mbox_evt = ev; mbox_clr = cl;
    {busoff_evt, passive_evt, warn_evt} = sys;
    @(negedge clk);
    mbox_evt = '0; mbox_clr = '0;
    {busoff_evt, passive_evt, warn_evt} = 3'b0;
  endtask

  task automatic chk_irq(input logic e0, input logic e1, input string tag);
    @(negedge clk);
    chk({tag, " irq0"}, 32'(irq_line0), 32'(e0));
    chk({tag, " irq1"}, 32'(irq_line1), 32'(e1));
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 32'h0, "R1 reset reg");
    chk_irq(1'b0, 1'b0, "R1 reset");

    // R7 configuration and readback
    wr(3'd0, 32'h8010_00A8);          // mailboxes 3,5,7,20,31 enabled
    wr(3'd1, 32'h8010_0000);          // 20 and 31 on line 1
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, 32'h0000_0707, "R7 gmask stored bits");
    wr(3'd2, 32'h0000_0703);
    rd(3'd0, 32'h8010_00A8, "R7 mask readback");
    rd(3'd1, 32'h8010_0000, "R7 level readback");
    rd(3'd2, 32'h0000_0703, "R7 gmask readback");
    rd(3'd6, 32'h0, "R7 unused addr");

    // R2 masked-off mailbox ignored
    pulse(N'(1) << 9, '0, 3'b0);
    rd(3'd3, 32'h0, "R2 masked mailbox ignored");
    chk_irq(1'b0, 1'b0, "R2 masked mailbox");

    // R2/R6 mailbox 3 on line 0
    pulse(N'(1) << 3, '0, 3'b0);
    chk_irq(1'b1, 1'b0, "R6 mailbox 3");
    rd(3'd3, 32'h0000_8003, "R2 mailbox 3 flag0");

    // R3 priority ordering
    pulse((N'(1) << 5) | (N'(1) << 7), '0, 3'b0);
    rd(3'd3, 32'h0000_8007, "R3 highest pending");
    pulse('0, N'(1) << 7, 3'b0);
    rd(3'd3, 32'h0000_8005, "R3 next after clear 7");
    pulse('0, N'(1) << 5, 3'b0);
    rd(3'd3, 32'h0000_8003, "R3 next after clear 5");
    pulse('0, N'(1) << 3, 3'b0);
    rd(3'd3, 32'h0, "R3 none pending");
    chk_irq(1'b0, 1'b0, "R6 all cleared");

    // R2 line 1 routing
    pulse(N'(1) << 31, '0, 3'b0);
    chk_irq(1'b0, 1'b1, "R2 mailbox 31 line1");
    rd(3'd4, 32'h0000_801F, "R2 mailbox 31 flag1");
    rd(3'd3, 32'h0, "R2 line0 untouched");
    pulse(N'(1) << 20, '0, 3'b0);
    rd(3'd4, 32'h0000_801F, "R3 31 over 20");
    pulse('0, N'(1) << 31, 3'b0);
    rd(3'd4, 32'h0000_8014, "R3 20 after 31 cleared");
    // R5 write does not touch mailbox part
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0000_8014, "R5 mailbox bits kept");
    pulse('0, N'(1) << 20, 3'b0);
    chk_irq(1'b0, 1'b0, "R6 line1 idle");

    // R4/R5 status flags on line 0
    pulse('0, '0, 3'b001);
    chk_irq(1'b1, 1'b0, "R6 warn");
    rd(3'd3, 32'h0000_0100, "R4 warn flag");
    pulse('0, '0, 3'b010);
    rd(3'd3, 32'h0000_0300, "R4 passive flag");
    wr(3'd3, 32'h0000_0100);
    rd(3'd3, 32'h0000_0200, "R5 per-bit clear");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'h0, "R5 all ones clear");
    chk_irq(1'b0, 1'b0, "R5 cleared irq");

    // R6 status enable gating
    wr(3'd2, 32'h0000_0303);
    pulse('0, '0, 3'b100);
    rd(3'd3, 32'h0000_0400, "R4 busoff flag");
    chk_irq(1'b0, 1'b0, "R6 busoff disabled");
    wr(3'd3, 32'hFFFF_FFFF);

    // R4 status to line 1
    wr(3'd2, 32'h0000_0707);
    pulse('0, '0, 3'b001);
    rd(3'd4, 32'h0000_0100, "R4 warn on line1");
    rd(3'd3, 32'h0, "R4 line0 clear");
    chk_irq(1'b0, 1'b1, "R4 line1 irq");
    wr(3'd4, 32'hFFFF_FFFF);

    // R6 line enable gating
    wr(3'd2, 32'h0000_0706);
    pulse(N'(1) << 3, '0, 3'b0);
    rd(3'd3, 32'h0000_8003, "R6 flag set line disabled");
    chk_irq(1'b0, 1'b0, "R6 line0 disabled");

    // R8 event wins over clear
    pulse(N'(1) << 3, N'(1) << 3, 3'b0);
    rd(3'd3, 32'h0000_8003, "R8 mailbox evt wins");
    pulse('0, N'(1) << 3, 3'b0);
    rd(3'd3, 32'h0, "R8 later clear works");
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'hFFFF_FFFF; warn_evt = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; warn_evt = 1'b0;
    rd(3'd4, 32'h0000_0100, "R8 status evt wins");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule